// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block sends packets from a circular chain of transmit descriptors kept in a word-addressed memory. A descriptor takes three consecutive words. The word at the descriptor pointer is the link to the next descriptor. The word after it is the command/status word. The third word is the byte address of the buffer. Software first loads the pointer. It then fills descriptors, sets their ownership bits and pulses `start`.

The engine reads the command/status word first. If the descriptor belongs to hardware, the engine reads the link and the buffer address. It then sends the buffer one byte at a time on a ready/valid stream. After the last byte is accepted, it writes the completion status into the same descriptor, which returns ownership to the host. It then follows the link and repeats. When it reaches a descriptor that software has not handed over, it stops and signals idle.

A start pulse given later resumes at that same descriptor. A descriptor can flag that the packet continues in the next descriptor. In that case the end-of-packet marker appears only on the final byte of the chain. One-cycle pulses report three events: a completion that requested an interrupt, a failed transmission, and an idle stop. An error-injection input makes the written-back status report a FIFO underrun.

Top module: `tx_desc_ring`

## Requirements
- R1: While `rst_n` is low at a clock edge, and in the first cycle after it, `tx_valid`, `mem_req` and all three interrupt pulses are 0.
- R2: On `start` in idle, the engine reads the command/status word at pointer+1. If bit 31 (ownership) of that word is 0, no byte is sent and nothing is written. `irq_idle` pulses high for exactly one cycle and the engine returns to idle.
- R3: For an owned descriptor, the link is read from pointer+0 and the buffer byte address from pointer+2. The engine then sends bits 11:0 (length) of the command word as that many bytes, in rising address order. The byte at byte address b is bits 8*(b mod 4)+7 : 8*(b mod 4) of memory word b/4.
- R4: `tx_last` is high only on the final byte of a descriptor whose bit 30 (more) is 0. It is never high on a descriptor whose bit 30 is 1.
- R5: Once the final byte is accepted, the engine writes the status word back to pointer+1. Bit 31 is 0 and bits 30:28 and 15:0 are kept from the command word. Bit 27 (ok) is 1 and bits 26:16 are 0.
- R6: If `err_inject` is high on any accepted byte of a descriptor, its written-back status has bit 27 at 0 and bit 25 (underrun) at 1. `irq_err` then pulses for one cycle.
- R7: `irq_desc` pulses for one cycle after a write-back only if bit 29 (interrupt request) of that descriptor was 1.
- R8: After a write-back, the pointer takes the link value and the next descriptor is fetched without a new `start`. A ring whose last link points to its first descriptor is walked until a descriptor that is not owned is found.
- R9: A `start` while the engine is busy has no effect. A `start` in idle resumes at the descriptor that stopped the previous run.
- R10: `ptr_load` in idle sets the descriptor pointer to `ptr_value`. A `start` in the same or a later cycle fetches from it.
- R11: A descriptor of length 0 sends no byte but is still written back with status as in R5.
- R12: A memory request keeps its address, write enable and write data until `mem_gnt`. A valid byte keeps its data and `tx_last` until `tx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Transmit-enable pulse |
| ptr_load | input | 1 | Load descriptor pointer (idle only) |
| ptr_value | input | AW | Word address of a descriptor |
| err_inject | input | 1 | Marks accepted bytes as underrun |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Write data (status word) |
| mem_gnt | input | 1 | Request granted this cycle |
| mem_rdata | input | 32 | Read data, valid in the grant cycle |
| tx_valid | output | 1 | Byte on `tx_data` is valid |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_data | output | 8 | Byte stream |
| tx_last | output | 1 | Final byte of the packet |
| irq_desc | output | 1 | Completed descriptor requested an interrupt |
| irq_err | output | 1 | Completed descriptor reported an error |
| irq_idle | output | 1 | Unowned descriptor found, engine stopped |

## Verification
The assertions assume the memory returns read data combinationally in the cycle `mem_gnt` is high. They also assume `mem_gnt` and `tx_ready` may drop for any number of cycles. The bench's memory model answers from its array in the same cycle. Grant and ready follow fixed stall patterns that never hold either low for long. The assertions also assume that software changes no descriptor the engine currently owns. The bench rewrites descriptors only while the engine is idle.

// File: rtl/tdr_pkg.sv
// Shared state type and command/status bit positions for the descriptor engine.
// Assumes 32-bit memory words and a 12-bit length field.
package tdr_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_CMD, S_LINK, S_BUF, S_DATA, S_SEND, S_WB
    } tdr_state_t;

    localparam int OWN_B  = 31;
    localparam int MORE_B = 30;
    localparam int IREQ_B = 29;
    localparam int LEN_W  = 12;
endpackage

// File: rtl/tdr_lane_pick.sv
// Selects one byte lane of a memory word, lowest address in the lowest lane.
// Assumes DW is a whole multiple of BW.
module tdr_lane_pick #(
    parameter int DW = 32,
    parameter int BW = 8,
    localparam int LANES = DW / BW,
    localparam int SW = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [DW-1:0] word,
    input  logic [SW-1:0] sel,
    output logic [BW-1:0] lane
);
    logic [BW-1:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word[g*BW +: BW];
    end

    assign lane = lanes[sel];
endmodule

// File: rtl/tdr_stat_pack.sv
// Builds the write-back word: owner cleared, flags and length kept, outcome bits set.
// Assumes only underrun can fail; collision count is always zero.
module tdr_stat_pack (
    input  logic [2:0]  flags,
    input  logic [15:0] low,
    input  logic        urun,
    output logic [31:0] status
);
    // Pack fields: own, more/irq/nocrc, ok, abort, underrun, zeros, length.
    assign status = {1'b0, flags, ~urun, 1'b0, urun, 9'd0, low};
endmodule

// File: rtl/tdr_seq.sv
// Sequencer: fetches a descriptor, streams its buffer, writes status, follows link.
// Assumes read data is valid in the cycle a request is granted.
module tdr_seq
    import tdr_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          ptr_load,
    input  logic [AW-1:0] ptr_value,
    input  logic          err_inject,
    input  logic          mem_gnt,
    input  logic [31:0]   mem_rdata,
    input  logic [7:0]    rd_byte,
    input  logic          tx_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    lane_sel,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    output logic          irq_desc,
    output logic          irq_err,
    output logic          irq_idle,
    output logic [2:0]    flags,
    output logic [15:0]   len_low,
    output logic          urun
);
    tdr_state_t       state;
    logic [AW-1:0]    ptr;
    logic [AW-1:0]    link;
    logic [31:0]      baddr;
    logic [LEN_W-1:0] remain;
    logic [7:0]       byte_q;

    // Memory request type and address follow the current state.
    always_comb begin
        mem_req = 1'b1;
        mem_we  = 1'b0;
        case (state)
            S_CMD:   mem_addr = ptr + AW'(1);
            S_LINK:  mem_addr = ptr;
            S_BUF:   mem_addr = ptr + AW'(2);
            S_DATA:  mem_addr = baddr[AW+1:2];
            S_WB: begin
                mem_addr = ptr + AW'(1);
                mem_we   = 1'b1;
            end
            default: begin
                mem_addr = ptr;
                mem_req  = 1'b0;
            end
        endcase
    end

    assign lane_sel = baddr[1:0];
    assign tx_valid = (state == S_SEND);
    assign tx_data  = byte_q;
    assign tx_last  = (state == S_SEND) && (remain == LEN_W'(1)) && !flags[MORE_B-28];

    // Main sequencing, pointer tracking and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            ptr      <= '0;
            link     <= '0;
            baddr    <= '0;
            remain   <= '0;
            byte_q   <= '0;
            flags    <= '0;
            len_low  <= '0;
            urun     <= 1'b0;
            irq_desc <= 1'b0;
            irq_err  <= 1'b0;
            irq_idle <= 1'b0;
        end else begin
            irq_desc <= 1'b0;
            irq_err  <= 1'b0;
            irq_idle <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (ptr_load) ptr <= ptr_value;
                    if (start) state <= S_CMD;
                end
                S_CMD: if (mem_gnt) begin
                    if (mem_rdata[OWN_B]) begin
                        flags   <= mem_rdata[30:28];
                        len_low <= mem_rdata[15:0];
                        state   <= S_LINK;
                    end else begin
                        irq_idle <= 1'b1;
                        state    <= S_IDLE;
                    end
                end
                S_LINK: if (mem_gnt) begin
                    link  <= mem_rdata[AW-1:0];
                    state <= S_BUF;
                end
                S_BUF: if (mem_gnt) begin
                    baddr  <= mem_rdata;
                    remain <= len_low[LEN_W-1:0];
                    state  <= (len_low[LEN_W-1:0] == '0) ? S_WB : S_DATA;
                end
                S_DATA: if (mem_gnt) begin
                    byte_q <= rd_byte;
                    state  <= S_SEND;
                end
                S_SEND: if (tx_ready) begin
                    if (err_inject) urun <= 1'b1;
                    remain <= remain - LEN_W'(1);
                    baddr  <= baddr + 32'd1;
                    state  <= (remain == LEN_W'(1)) ? S_WB : S_DATA;
                end
                S_WB: if (mem_gnt) begin
                    irq_desc <= flags[IREQ_B-28];
                    irq_err  <= urun;
                    urun     <= 1'b0;
                    ptr      <= link;
                    state    <= S_CMD;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tx_desc_ring.sv
// Top: transmit descriptor ring engine. Joins the sequencer, byte-lane select
// and status packer. Assumes a single-cycle request/grant memory port.
module tx_desc_ring #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          ptr_load,
    input  logic [AW-1:0] ptr_value,
    input  logic          err_inject,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_gnt,
    input  logic [31:0]   mem_rdata,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    output logic          irq_desc,
    output logic          irq_err,
    output logic          irq_idle
);
    logic [7:0]  rd_byte;
    logic [1:0]  lane_sel;
    logic [2:0]  flags;
    logic [15:0] len_low;
    logic        urun;

    tdr_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .ptr_load(ptr_load),
        .ptr_value(ptr_value), .err_inject(err_inject), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .rd_byte(rd_byte), .tx_ready(tx_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .lane_sel(lane_sel), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .irq_desc(irq_desc), .irq_err(irq_err),
        .irq_idle(irq_idle), .flags(flags), .len_low(len_low), .urun(urun)
    );

    tdr_lane_pick #(.DW(32), .BW(8)) u_lane (
        .word(mem_rdata), .sel(lane_sel), .lane(rd_byte)
    );

    tdr_stat_pack u_pack (
        .flags(flags), .low(len_low), .urun(urun), .status(mem_wdata)
    );
endmodule

// File: rtl/tdr_chk.sv
// Protocol checker for the descriptor engine, attached by bind.
// Assumes grant and ready may be withheld for any number of cycles.
module tdr_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_gnt,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [7:0]    tx_data,
    input logic          tx_last,
    input logic          irq_desc,
    input logic          irq_err,
    input logic          irq_idle
);
    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
    // R12
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data) && $stable(tx_last));
    // R5
    owner_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_wdata[31]);
    // R5
    wb_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> !tx_valid);
    // R5
    no_mem_while_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !mem_req);
    // R2
    idle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_idle |=> !irq_idle);
    // R7
    irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_idle |-> !(irq_desc || irq_err));
endmodule

bind tx_desc_ring tdr_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .irq_desc(irq_desc), .irq_err(irq_err),
    .irq_idle(irq_idle)
);

// File: tb/tb_tx_desc_ring.sv
module tb_tx_desc_ring;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0, ptr_load = 1'b0, err_inject = 1'b0;
    logic [AW-1:0] ptr_value = '0;
    logic          mem_req, mem_we, mem_gnt = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata;
    logic          tx_valid, tx_ready = 1'b0, tx_last;
    logic [7:0]    tx_data;
    logic          irq_desc, irq_err, irq_idle;

    logic [31:0] mem [0:(1<<AW)-1];
    logic [7:0]  cap [0:63];
    int cap_n = 0, last_n = 0, last_at = -1, wr_n = 0;
    int n_desc = 0, n_err = 0, n_idle = 0, cyc = 0;
    int n_chk = 0, n_bad = 0, hold_bad = 0;
    logic hold_q = 1'b0;
    logic [8:0] hold_v = '0;

    always #4 clk = ~clk;   // 125 MHz

    tx_desc_ring #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ptr_load(ptr_load),
        .ptr_value(ptr_value), .err_inject(err_inject), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
        .irq_desc(irq_desc), .irq_err(irq_err), .irq_idle(irq_idle)
    );

    assign mem_rdata = mem[mem_addr];

    function automatic logic [7:0] pb(input int b);
        return 8'((b * 7 + 3) & 255);
    endfunction

    // Stall patterns for grant and ready, driven away from the active edge.
    always @(negedge clk) begin
        cyc++;
        mem_gnt  = (cyc % 3) != 1;
        tx_ready = (cyc % 4) != 2;
    end

    // Memory writes, byte capture, event counting, hold checking (R12).
    always @(posedge clk) begin
        if (rst_n) begin
            if (hold_q && !(tx_valid && {tx_last, tx_data} == hold_v)) hold_bad++;
            hold_q = tx_valid && !tx_ready;
            hold_v = {tx_last, tx_data};
            if (mem_req && mem_gnt && mem_we) begin
                mem[mem_addr] = mem_wdata;
                wr_n++;
            end
            if (tx_valid && tx_ready) begin
                if (cap_n < 64) cap[cap_n] = tx_data;
                if (tx_last) begin last_n++; last_at = cap_n; end
                cap_n++;
            end
            if (irq_desc) n_desc++;
            if (irq_err)  n_err++;
            if (irq_idle) n_idle++;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_cap();
        cap_n = 0; last_n = 0; last_at = -1; wr_n = 0;
        n_desc = 0; n_err = 0; n_idle = 0;
    endtask

    task automatic load_ptr(input int p);
        @(negedge clk); ptr_load = 1'b1; ptr_value = AW'(p);
        @(negedge clk); ptr_load = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_idle(input int target);
        for (int k = 0; k < 5000 && n_idle < target; k++) @(negedge clk);
        chk("R8", "engine reached idle", int'(n_idle >= target), 1);
        repeat (3) @(negedge clk);
    endtask

    task automatic set_desc(input int d, input int link, input int cmd, input int buf_b);
        mem[d] = 32'(link); mem[d+1] = 32'(cmd); mem[d+2] = 32'(buf_b);
    endtask

    function automatic int mk_cmd(input int len, input bit more, input bit irq);
        return int'({1'b1, more, irq, 1'b0, 16'd0, 12'(len)});
    endfunction

    function automatic int mk_stat(input int len, input bit more, input bit irq, input bit err);
        return int'({1'b0, more, irq, 1'b0, ~err, 1'b0, err, 9'd0, 4'd0, 12'(len)});
    endfunction

    // Vectors: [31] err, [30] irq, [29] more, [27:16] buffer offset, [11:0] length.
    localparam logic [31:0] VEC [6] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 12'd0, 4'd0, 12'd5},
        {1'b0, 1'b1, 1'b0, 1'b0, 12'd3, 4'd0, 12'd8},
        {1'b0, 1'b0, 1'b1, 1'b0, 12'd2, 4'd0, 12'd1},
        {1'b1, 1'b1, 1'b0, 1'b0, 12'd1, 4'd0, 12'd6},
        {1'b0, 1'b1, 1'b1, 1'b0, 12'd0, 4'd0, 12'd13},
        {1'b1, 1'b0, 1'b0, 1'b0, 12'd4, 4'd0, 12'd4}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R8 watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int w = 0; w < (1 << AW); w++)
            mem[w] = {pb(4*w+3), pb(4*w+2), pb(4*w+1), pb(4*w)};
        for (int w = 0; w < 64; w++) mem[w] = '0;
        for (int w = 200; w < 216; w++) mem[w] = '0;

        // R1: outputs quiet under reset and in the cycle after it.
        repeat (3) @(negedge clk);
        chk("R1", "tx_valid in reset", int'(tx_valid), 0);
        chk("R1", "mem_req in reset", int'(mem_req), 0);
        chk("R1", "irq pulses in reset", int'({irq_desc, irq_err, irq_idle}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "mem_req after reset", int'(mem_req), 0);

        // Table walk: one descriptor each, next descriptor unowned (R3..R7, R10).
        for (int i = 0; i < 6; i++) begin
            int d, len, base, mism;
            bit er, ir, mo;
            d = 4 * i; len = int'(VEC[i][11:0]);
            base = 256 + 64 * i + int'(VEC[i][27:16]);
            er = VEC[i][31]; ir = VEC[i][30]; mo = VEC[i][29];
            set_desc(d, d + 4, mk_cmd(len, mo, ir), base);
            clear_cap();
            err_inject = er;
            load_ptr(d);
            pulse_start();
            wait_idle(1);
            err_inject = 1'b0;
            mism = 0;
            for (int k = 0; k < len; k++) if (cap[k] !== pb(base + k)) mism++;
            chk("R3", "byte count", cap_n, len);
            chk("R3", "byte mismatches", mism, 0);
            chk("R4", "last markers", last_n, mo ? 0 : 1);
            if (!mo) chk("R4", "last position", last_at, len - 1);
            chk(er ? "R6" : "R5", "status word", int'(mem[d+1]), mk_stat(len, mo, ir, er));
            chk("R6", "irq_err pulses", n_err, int'(er));
            chk("R7", "irq_desc pulses", n_desc, int'(ir));
        end

        // R2: unowned descriptor yields idle only.
        clear_cap();
        load_ptr(40);
        pulse_start();
        wait_idle(1);
        chk("R2", "bytes from unowned", cap_n, 0);
        chk("R2", "writes from unowned", wr_n, 0);
        chk("R2", "idle pulses", n_idle, 1);

        // R11: zero-length descriptor still written back.
        clear_cap();
        set_desc(48, 52, mk_cmd(0, 1'b0, 1'b1), 400);
        load_ptr(48);
        pulse_start();
        wait_idle(1);
        chk("R11", "bytes for zero length", cap_n, 0);
        chk("R11", "status word", int'(mem[49]), 32'h2800_0000);
        chk("R11", "irq_desc", n_desc, 1);

        // R8/R4/R9: three-descriptor ring, one packet, start pulsed while busy.
        clear_cap();
        set_desc(200, 204, mk_cmd(3, 1'b1, 1'b0), 700);
        set_desc(204, 208, mk_cmd(2, 1'b1, 1'b1), 720);
        set_desc(208, 200, mk_cmd(4, 1'b0, 1'b0), 740);
        load_ptr(200);
        pulse_start();
        for (int k = 0; k < 200 && cap_n < 1; k++) @(negedge clk);
        pulse_start();
        wait_idle(1);
        begin
            int mism, idx;
            mism = 0; idx = 0;
            for (int k = 0; k < 3; k++) begin if (cap[idx] !== pb(700 + k)) mism++; idx++; end
            for (int k = 0; k < 2; k++) begin if (cap[idx] !== pb(720 + k)) mism++; idx++; end
            for (int k = 0; k < 4; k++) begin if (cap[idx] !== pb(740 + k)) mism++; idx++; end
            chk("R8", "ring byte count", cap_n, 9);
            chk("R8", "ring byte mismatches", mism, 0);
        end
        chk("R4", "ring last markers", last_n, 1);
        chk("R4", "ring last position", last_at, 8);
        chk("R8", "first status", int'(mem[201]), mk_stat(3, 1'b1, 1'b0, 1'b0));
        chk("R8", "wrapped status", int'(mem[209]), mk_stat(4, 1'b0, 1'b0, 1'b0));
        chk("R9", "idle pulses with busy start", n_idle, 1);

        // R9: resume at the descriptor that stopped the ring.
        clear_cap();
        mem[201] = 32'(mk_cmd(2, 1'b0, 1'b0));
        mem[202] = 32'd760;
        pulse_start();
        wait_idle(1);
        chk("R9", "resumed byte count", cap_n, 2);
        chk("R9", "resumed first byte", int'(cap[0]), int'(pb(760)));
        chk("R9", "resumed second byte", int'(cap[1]), int'(pb(761)));

        // R12: stream held while the sink stalls.
        chk("R12", "hold violations", hold_bad, 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule